// File: doc/BRIEF.md
# Shared Address/Data Bus Transaction Sequencer

This block turns single-word load and store requests from a processor-side port into transactions on a memory bus. On that bus, one set of lines carries the address and the data in turn, and a command strobe and a write flag travel with the address. Because the lines are shared, every transaction runs as a short sequence of phases.

A read has three steps. The sequencer first puts the address on the lines with the write flag low. The memory then fetches the word and drives it back. The sequencer captures that word and returns it to the requester. A write also starts with an address phase, this time with the write flag high. In the next phase the sequencer drives the store data on the same lines, and the memory keeps that data at the address it latched.

The requester uses a req/ack handshake. It holds `req` and its fields steady until it sees a one-cycle `ack`. A small memory model with a programmable response delay sits beside the sequencer, so the whole transaction can be exercised. The bus lines are brought out so that the phases and the drive ownership can be observed.

Top module: `mbs_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `ack`, `bus_m_drive` and `bus_s_drive` are 0 and `rdata` is 0.
- R2: One cycle after a read request is taken in the idle state, the sequencer holds `bus_cmd`=1 and `bus_we`=0 for exactly one cycle. In that cycle it drives the bus (`bus_m_drive`=1), and `bus_data` carries the request address zero-extended.
- R3: A write request gets the same single address phase as R2, one cycle after it is taken, but with `bus_we`=1.
- R4: From the cycle after a write's address phase until the memory's ready pulse, the sequencer drives `bus_data` with the store word. During this phase `bus_cmd` is 0.
- R5: The memory keeps the store word at the address from the write's address phase. A later read of that address returns it, and the value stays in place until it is overwritten.
- R6: The memory raises `bus_ready` for one cycle, LATENCY cycles after the address phase. On a read, only in that cycle, it drives (`bus_s_drive`=1) the stored word on `bus_data`.
- R7: `ack` is a one-cycle pulse, LATENCY+2 cycles after the cycle in which the request was taken. During a read's ack, `rdata` equals the word the memory returned. `rdata` changes only in an ack cycle of a read, so a write leaves it unchanged.
- R8: The sequencer and the memory never drive the bus in the same cycle. When neither drives, `bus_data` reads 0.
- R9: A request is taken only in the idle state. If `req` stays high through `ack`, the next transaction's address phase follows two cycles after the ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request; held until ack |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store word |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last loaded word |
| bus_data | output | DATA_W | Shared address/data lines |
| bus_cmd | output | 1 | Address-phase strobe |
| bus_we | output | 1 | Write flag, valid with bus_cmd |
| bus_ready | output | 1 | Memory ready pulse |
| bus_m_drive | output | 1 | Sequencer drives the lines |
| bus_s_drive | output | 1 | Memory drives the lines |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=16 and LATENCY=3. A 16-word memory lets it store to and load from both end addresses, 0 and 15, and overwrite a location. A latency of 3 stretches the write data phase over several cycles, so the bench can check that the store word is held, and that the lines stay free of a second driver, across the whole wait. Keeping `req` high through an ack gives back-to-back transactions, which exercises the rule that a request is taken only in the idle state.

// File: rtl/mbs_pkg.sv
// Shared types for the shared-bus sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package mbs_pkg;

    // Sequencer phases; one transaction walks IDLE->ADDR->(RD_WAIT|WR_DATA)->DONE.
    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_ADDR    = 3'd1,
        SQ_RD_WAIT = 3'd2,
        SQ_WR_DATA = 3'd3,
        SQ_DONE    = 3'd4
    } seq_state_t;

endpackage

// File: rtl/mbs_master.sv
// Bus master sequencer: takes one load/store request in idle and drives the
// address phase, then either waits for and captures the returned word or
// drives the store word until the memory signals ready, then pulses ack.
// Assumes: the requester holds req and its fields until ack; DATA_W >= ADDR_W.
module mbs_master
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              m_oe,
    output logic [DATA_W-1:0] m_bus,
    output logic              m_cmd,
    output logic              m_we,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              s_ready
);

    seq_state_t        state, state_nx;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:    if (req) state_nx = SQ_ADDR;
            SQ_ADDR:    state_nx = we_q ? SQ_WR_DATA : SQ_RD_WAIT;
            SQ_RD_WAIT: if (s_ready) state_nx = SQ_DONE;
            SQ_WR_DATA: if (s_ready) state_nx = SQ_DONE;
            SQ_DONE:    state_nx = SQ_IDLE;
            default:    state_nx = SQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // Latch the request fields at acceptance; they are ignored afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state == SQ_IDLE && req) begin
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the returned word on the memory's ready pulse of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rdata_q <= '0;
        else if (state == SQ_RD_WAIT && s_ready) rdata_q <= bus_in;
    end

    // Bus drive and requester outputs, decoded from the phase.
    always_comb begin
        m_oe  = (state == SQ_ADDR) || (state == SQ_WR_DATA);
        m_cmd = (state == SQ_ADDR);
        m_we  = (state == SQ_ADDR) && we_q;
        if (state == SQ_ADDR)         m_bus = DATA_W'(addr_q);
        else if (state == SQ_WR_DATA) m_bus = wdata_q;
        else                          m_bus = '0;
    end

    assign ack   = (state == SQ_DONE);
    assign rdata = rdata_q;

    // R7: completion is a single-cycle pulse.
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7: the returned word moves only together with ack.
    p_rdata_moves_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> ack);

    // R2: the address strobe lasts one cycle.
    p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_cmd |=> !m_cmd);

    // R4: a write address phase is followed by a data phase driven by the master.
    p_wdata_after_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd && m_we) |=> (m_oe && !m_cmd));

endmodule

// File: rtl/mbs_memory.sv
// Memory slave model: latches the address in the command phase, waits
// LATENCY cycles from that phase, then raises ready for one cycle, driving
// the stored word on a read or storing the bus word on a write.
// Assumes: no new command while a transaction is open; LATENCY >= 1.
module mbs_memory #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd,
    input  logic              we,
    input  logic [DATA_W-1:0] bus_in,
    output logic              s_oe,
    output logic [DATA_W-1:0] s_bus,
    output logic              s_ready
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              busy;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt;

    // Transaction tracking and response delay count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            we_q   <= 1'b0;
            addr_q <= '0;
            cnt    <= '0;
        end else if (!busy) begin
            if (cmd) begin
                busy   <= 1'b1;
                we_q   <= we;
                addr_q <= bus_in[ADDR_W-1:0];
                cnt    <= CNT_W'(LATENCY - 1);
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Storage array; written with the bus word on a write's ready cycle.
    always_ff @(posedge clk) begin
        if (s_ready && we_q) mem[addr_q] <= bus_in;
    end

    assign s_ready = busy && (cnt == '0);
    assign s_oe    = s_ready && !we_q;
    assign s_bus   = s_oe ? mem[addr_q] : '0;

    // R6: the ready pulse lasts one cycle.
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R9: the master never opens a transaction while the memory is busy.
    p_no_cmd_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd |-> !busy);

endmodule

// File: rtl/mbs_bus_join.sv
// Shared-line model: OR-combines the gated drives of master and memory so
// that a double drive corrupts the lines, as on a real shared bus.
// Assumes: each side forces its drive value to 0 when not enabled.
module mbs_bus_join #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_oe,
    input  logic [DATA_W-1:0] m_bus,
    input  logic              s_oe,
    input  logic [DATA_W-1:0] s_bus,
    output logic [DATA_W-1:0] bus
);

    // Resolve the line value from both drivers.
    always_comb begin
        bus = (m_oe ? m_bus : '0) | (s_oe ? s_bus : '0);
    end

    // R8: only one side drives in any cycle.
    p_single_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_oe && s_oe));

endmodule

// File: rtl/mbs_top.sv
// Top level: sequencer, shared lines and memory model, with the lines
// brought out for observation.
// Assumes: DATA_W >= ADDR_W so an address fits on the data lines.
module mbs_top #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_cmd,
    output logic              bus_we,
    output logic              bus_ready,
    output logic              bus_m_drive,
    output logic              bus_s_drive
);

    logic [DATA_W-1:0] m_bus, s_bus;

    mbs_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk(clk), .rst_n(rst_n),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata),
        .m_oe(bus_m_drive), .m_bus(m_bus), .m_cmd(bus_cmd), .m_we(bus_we),
        .bus_in(bus_data), .s_ready(bus_ready)
    );

    mbs_bus_join #(.DATA_W(DATA_W)) u_join (
        .clk(clk), .rst_n(rst_n),
        .m_oe(bus_m_drive), .m_bus(m_bus),
        .s_oe(bus_s_drive), .s_bus(s_bus),
        .bus(bus_data)
    );

    mbs_memory #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATENCY(LATENCY)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .cmd(bus_cmd), .we(bus_we), .bus_in(bus_data),
        .s_oe(bus_s_drive), .s_bus(s_bus), .s_ready(bus_ready)
    );

endmodule

// File: tb/mbs_top_tb.sv
// Scoreboard bench: the driver pushes expected transactions, the monitor
// checks each bus phase and the completion against them.
module mbs_top_tb;

    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack, bus_cmd, bus_we, bus_ready, bus_m_drive, bus_s_drive;
    logic [DW-1:0] rdata, bus_data;

    mbs_top #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .bus_data(bus_data), .bus_cmd(bus_cmd), .bus_we(bus_we),
        .bus_ready(bus_ready), .bus_m_drive(bus_m_drive), .bus_s_drive(bus_s_drive)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;   // store word, or expected load word
        logic [DW-1:0] rd_exp; // expected rdata at ack
        int            acc;
    } item_t;

    item_t         q[$];
    logic [DW-1:0] model [1<<AW];
    logic [DW-1:0] last_rd = '0;
    int            cyc = 0;
    int            n_chk = 0, n_bad = 0;
    logic          chained = 1'b0;
    logic          mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // Driver: issue one transaction and wait for its ack; keep req high if hold.
    task automatic run_txn(input logic we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic hold);
        item_t it;
        if (!chained) @(negedge clk);
        it.we   = we;
        it.addr = a;
        it.acc  = chained ? cyc + 1 : cyc;
        if (we) begin
            it.data = d;
            model[a] = d;
        end else begin
            it.data = model[a];
            last_rd = model[a];
        end
        it.rd_exp = last_rd;
        q.push_back(it);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!ack);
        if (!hold) req = 1'b0;
        chained = hold;
    endtask

    // Monitor: phase checks against the head of the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            check(!(bus_m_drive && bus_s_drive), "R8 double drive",
                  {15'd0, bus_s_drive}, 16'd0);
            if (!bus_m_drive && !bus_s_drive)
                check(bus_data == '0, "R8 idle lines", bus_data, 16'd0);
            if (q.size() == 0) begin
                if (ack) check(1'b0, "R7 unexpected ack", 16'd1, 16'd0);
                if (bus_cmd) check(1'b0, "R9 unexpected address phase", 16'd1, 16'd0);
            end else begin
                if (cyc == q[0].acc + 1) begin
                    check(bus_cmd && bus_m_drive, q[0].we ? "R3 addr strobe" : "R2 addr strobe",
                          {14'd0, bus_cmd, bus_m_drive}, 16'd3);
                    check(bus_we == q[0].we, q[0].we ? "R3 write flag" : "R2 write flag",
                          {15'd0, bus_we}, {15'd0, q[0].we});
                    check(bus_data == DW'(q[0].addr), "R2 R3 address on lines",
                          bus_data, DW'(q[0].addr));
                end else if (bus_cmd) begin
                    check(1'b0, "R9 address phase off schedule", cyc[15:0], 16'(q[0].acc + 1));
                end
                if (q[0].we && cyc >= q[0].acc + 2 && cyc <= q[0].acc + LAT + 1)
                    check(bus_m_drive && !bus_cmd && bus_data == q[0].data,
                          "R4 store word driven", bus_data, q[0].data);
                if (cyc == q[0].acc + LAT + 1) begin
                    check(bus_ready, "R6 ready timing", {15'd0, bus_ready}, 16'd1);
                    if (!q[0].we)
                        check(bus_s_drive && bus_data == q[0].data, "R6 R5 returned word",
                              bus_data, q[0].data);
                end else if (bus_ready) begin
                    check(1'b0, "R6 ready off schedule", cyc[15:0], 16'(q[0].acc + LAT + 1));
                end
                if (cyc == q[0].acc + LAT + 2) begin
                    check(ack, "R7 ack timing", {15'd0, ack}, 16'd1);
                    check(rdata == q[0].rd_exp, q[0].we ? "R7 rdata kept over write" : "R7 rdata",
                          rdata, q[0].rd_exp);
                    void'(q.pop_front());
                end else if (ack) begin
                    check(1'b0, "R7 ack off schedule", cyc[15:0], 16'(q[0].acc + LAT + 2));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!ack && !bus_m_drive && !bus_s_drive, "R1 reset outputs",
              {13'd0, ack, bus_m_drive, bus_s_drive}, 16'd0);
        check(rdata == '0, "R1 reset rdata", rdata, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ack && !bus_m_drive && !bus_s_drive && rdata == '0, "R1 after reset",
              {13'd0, ack, bus_m_drive, bus_s_drive}, 16'd0);
        mon_on = 1'b1;

        // R3 R4 R5: stores at both end addresses and the middle.
        run_txn(1'b1, 4'd0,  16'hFFFF, 1'b0);
        run_txn(1'b1, 4'd15, 16'hA5C3, 1'b0);
        run_txn(1'b1, 4'd5,  16'h0001, 1'b0);
        // R2 R5 R6 R7: load them back.
        run_txn(1'b0, 4'd15, 16'h0, 1'b0);
        run_txn(1'b0, 4'd0,  16'h0, 1'b0);
        run_txn(1'b0, 4'd5,  16'h0, 1'b0);
        // R7: a store keeps the last loaded word on rdata.
        run_txn(1'b1, 4'd9,  16'h8000, 1'b0);
        // R5: overwrite then read.
        run_txn(1'b1, 4'd0,  16'h0000, 1'b0);
        run_txn(1'b0, 4'd0,  16'h0, 1'b0);
        // R9: req held high through ack, back-to-back mixed traffic.
        run_txn(1'b1, 4'd3,  16'h1234, 1'b1);
        run_txn(1'b0, 4'd3,  16'h0, 1'b1);
        run_txn(1'b1, 4'd15, 16'h5A5A, 1'b1);
        run_txn(1'b0, 4'd15, 16'h0, 1'b1);
        run_txn(1'b0, 4'd9,  16'h0, 1'b0);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R7 all transactions completed", 16'(q.size()), 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule